// File: doc/BRIEF.md
# FIFO Level Monitor with Ready Granularity and Flow Control

This block sits beside the receive and transmit FIFOs of a serial port and watches the occupancy count of each one. Three programmable levels are compared against those counts every cycle. Each level has a sticky flag that sets only when the count moves across the level in one given direction. A flag does not set just because the count sits at the level. The flags stay set until a clear strobe arrives.

The block also produces the two ready indications used by software or a DMA engine. The receive ready indication means that enough unread entries are present. The transmit ready indication means that enough free slots exist. The granularity is one, two or four entries. When its control bit is set, the block also drives an RTS flow-control output with hysteresis. RTS rises once receive occupancy reaches the upper receive level. It falls once occupancy drops to the lower receive level or below.

All settings live in one 32-bit mode word that is written and read through a plain port. The readback shows zero while the FIFOs are disabled. There is no data stream through this block. All of its pins are plain control and status.

Top module: `fifo_lvl_ctrl`

## Requirements
- R1: After reset, all three flags are 0, RTS is 0, and the mode word reads 0.
- R2: A write with `cfg_wr`=1 stores the mode word at the next clock edge. The fields are: lower receive level in bits 29:24, upper receive level in bits 21:16, transmit level in bits 13:8, RTS control enable in bit 7, receive granularity in bits 5:4 and transmit granularity in bits 1:0. While enabled, the readback is the stored word with all other bits 0 (mask 0x3F3F3FB3).
- R3: While `fifo_en`=0, `cfg_rdata` reads 0. The stored settings are kept, and they read back again once `fifo_en` returns to 1.
- R4: `rx_hi_flag` sets one edge after a cycle in which the receive count is at or above the upper receive level while the previous cycle's count was below it.
- R5: `rx_lo_flag` sets one edge after a cycle in which the receive count is at or below the lower receive level while the previous cycle's count was above it.
- R6: `tx_lo_flag` sets one edge after a cycle in which the transmit count is at or below the transmit level while the previous cycle's count was above it.
- R7: The flags are sticky. `flag_clr`=1 clears all three at the next edge, but a flag whose crossing happens in that same cycle stays set.
- R8: `rx_ready` is combinational and is 1 when the receive count is at least N. N is 1, 2 or 4 for receive granularity 0, 1 or 2. Encoding 3 behaves as encoding 0.
- R9: `tx_ready` is combinational and is 1 when DEPTH minus the transmit count is at least N. N is chosen from the transmit granularity with the same encoding as R8.
- R10: With RTS control enabled and `fifo_en`=1, `rts` becomes 1 one edge after a cycle in which the receive count is at or above the upper level. It becomes 0 one edge after a cycle in which the count is at or below the lower level and below the upper level. Otherwise it holds.
- R11: With RTS control disabled, `rts` is 0 one edge later, whatever the counts.
- R12: While `fifo_en`=0, no flag sets, both ready outputs use N=1, and `rts` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| cfg_wr | input | 1 | Mode word write strobe |
| cfg_wdata | input | 32 | Mode word write data |
| cfg_rdata | output | 32 | Mode word readback |
| rx_count | input | $clog2(DEPTH+1) | Receive FIFO occupancy |
| tx_count | input | $clog2(DEPTH+1) | Transmit FIFO occupancy |
| flag_clr | input | 1 | Clears all sticky flags |
| rx_hi_flag | output | 1 | Receive count crossed the upper level going up |
| rx_lo_flag | output | 1 | Receive count crossed the lower level going down |
| tx_lo_flag | output | 1 | Transmit count crossed its level going down |
| rx_ready | output | 1 | Enough unread receive entries |
| tx_ready | output | 1 | Enough free transmit slots |
| rts | output | 1 | Flow-control request to stop the remote sender |

## Verification
The bench builds the block with DEPTH=8, so each count runs from 0 to 8. This makes every ordered pair of previous and current counts cheap to visit. For each level setting from 0 to DEPTH+1, the bench visits all of those pairs, so every up and down crossing, every no-crossing and every level outside the count range is reached. The granularity encodings rotate with the level setting, which covers every encoding against every count. RTS control enabled and disabled and FIFOs disabled are each run over count sweeps.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;
  localparam int TH_W = 6;

  typedef enum logic [1:0] {
    GRAN_ONE  = 2'd0,
    GRAN_TWO  = 2'd1,
    GRAN_FOUR = 2'd2,
    GRAN_RSVD = 2'd3
  } gran_e;

  typedef struct packed {
    logic [TH_W-1:0] rx_lo_th;
    logic [TH_W-1:0] rx_hi_th;
    logic [TH_W-1:0] tx_lo_th;
    logic            rts_en;
    gran_e           rx_gran;
    gran_e           tx_gran;
  } lvl_cfg_t;

  // entries or slots demanded by a granularity code; reserved acts as one
  function automatic int gran_need(gran_e g);
    case (g)
      GRAN_TWO:  return 2;
      GRAN_FOUR: return 4;
      default:   return 1;
    endcase
  endfunction
endpackage

// File: rtl/fifo_lvl_cfg.sv
module fifo_lvl_cfg
  import fifo_lvl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        wr,
  input  logic [31:0] wdata,
  output lvl_cfg_t    cfg_q,
  output logic [31:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q.rx_lo_th <= wdata[29:24];
      cfg_q.rx_hi_th <= wdata[21:16];
      cfg_q.tx_lo_th <= wdata[13:8];
      cfg_q.rts_en   <= wdata[7];
      cfg_q.rx_gran  <= gran_e'(wdata[5:4]);
      cfg_q.tx_gran  <= gran_e'(wdata[1:0]);
    end
  end

  logic [31:0] packed_word;
  assign packed_word = {2'b00, cfg_q.rx_lo_th, 2'b00, cfg_q.rx_hi_th,
                        2'b00, cfg_q.tx_lo_th, cfg_q.rts_en, 1'b0,
                        cfg_q.rx_gran, 2'b00, cfg_q.tx_gran};
  assign rdata = en ? packed_word : 32'd0;
endmodule

// File: rtl/fifo_lvl_cross.sv
module fifo_lvl_cross #(
  parameter int CW   = 6,
  parameter int TW   = 6,
  parameter bit RISE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [CW-1:0] cnt,
  input  logic [TW-1:0] th,
  output logic          flag
);
  logic [CW-1:0] prev_q;
  logic          hit;

  generate
    if (RISE) begin : g_up
      assign hit = (int'(prev_q) < int'(th)) && (int'(cnt) >= int'(th));
    end else begin : g_down
      assign hit = (int'(prev_q) > int'(th)) && (int'(cnt) <= int'(th));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag   <= 1'b0;
    end else begin
      prev_q <= cnt;
      flag   <= (flag & ~clr) | (en & hit);
    end
  end
endmodule

// File: rtl/fifo_lvl_ready.sv
module fifo_lvl_ready
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic          en,
  input  gran_e         rx_gran,
  input  gran_e         tx_gran,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          rx_ready,
  output logic          tx_ready
);
  int rx_need, tx_need, tx_free;

  always_comb begin
    rx_need  = en ? gran_need(rx_gran) : 1;
    tx_need  = en ? gran_need(tx_gran) : 1;
    tx_free  = DEPTH - int'(tx_count);
    rx_ready = int'(rx_count) >= rx_need;
    tx_ready = tx_free >= tx_need;
  end
endmodule

// File: rtl/fifo_lvl_rts.sv
module fifo_lvl_rts #(
  parameter int CW = 6,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [CW-1:0] rx_count,
  input  logic [TW-1:0] th_hi,
  input  logic [TW-1:0] th_lo,
  output logic          rts
);
  logic go_high, go_low;
  assign go_high = int'(rx_count) >= int'(th_hi);
  assign go_low  = int'(rx_count) <= int'(th_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rts <= 1'b0;
    else if (!active) rts <= 1'b0;
    else if (go_high) rts <= 1'b1;
    else if (go_low)  rts <= 1'b0;
  end
endmodule

// File: rtl/fifo_lvl_ctrl.sv
module fifo_lvl_ctrl
  import fifo_lvl_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          cfg_wr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          flag_clr,
  output logic          rx_hi_flag,
  output logic          rx_lo_flag,
  output logic          tx_lo_flag,
  output logic          rx_ready,
  output logic          tx_ready,
  output logic          rts
);
  lvl_cfg_t cfg_q;

  fifo_lvl_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .en(fifo_en), .wr(cfg_wr),
    .wdata(cfg_wdata), .cfg_q(cfg_q), .rdata(cfg_rdata)
  );

  // slot 0: receive upward, slot 1: receive downward, slot 2: transmit downward
  logic [CW-1:0]   lvl [3];
  logic [TH_W-1:0] th  [3];
  logic [2:0]      flg;

  assign lvl[0] = rx_count;
  assign lvl[1] = rx_count;
  assign lvl[2] = tx_count;
  assign th[0]  = cfg_q.rx_hi_th;
  assign th[1]  = cfg_q.rx_lo_th;
  assign th[2]  = cfg_q.tx_lo_th;

  for (genvar g = 0; g < 3; g++) begin : g_cross
    fifo_lvl_cross #(.CW(CW), .TW(TH_W), .RISE(g == 0)) u_cross (
      .clk(clk), .rst_n(rst_n), .en(fifo_en), .clr(flag_clr),
      .cnt(lvl[g]), .th(th[g]), .flag(flg[g])
    );
  end

  assign rx_hi_flag = flg[0];
  assign rx_lo_flag = flg[1];
  assign tx_lo_flag = flg[2];

  fifo_lvl_ready #(.DEPTH(DEPTH), .CW(CW)) u_ready (
    .en(fifo_en), .rx_gran(cfg_q.rx_gran), .tx_gran(cfg_q.tx_gran),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_ready(rx_ready), .tx_ready(tx_ready)
  );

  fifo_lvl_rts #(.CW(CW), .TW(TH_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .active(fifo_en & cfg_q.rts_en),
    .rx_count(rx_count), .th_hi(cfg_q.rx_hi_th), .th_lo(cfg_q.rx_lo_th),
    .rts(rts)
  );
endmodule

// File: rtl/fifo_lvl_chk.sv
module fifo_lvl_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          flag_clr,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic [5:0]    th_hi,
  input logic          rts_en,
  input logic          rx_hi_flag,
  input logic          rx_ready,
  input logic          tx_ready,
  input logic          rts
);
  // R4: an upward flag rise needs the count at or above the level one edge before
  assert_rx_hi_reach_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_hi_flag) |-> int'($past(rx_count)) >= int'($past(th_hi)));

  // R7: a set flag survives any cycle without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hi_flag && !flag_clr) |=> rx_hi_flag);

  // R8: receive ready never claims data in an empty FIFO
  assert_rx_ready_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_count != '0);

  // R9: transmit ready never claims room in a full FIFO
  assert_tx_ready_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> int'(tx_count) < DEPTH);

  // R10: RTS rises only after the count reached the upper level
  assert_rts_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> int'($past(rx_count)) >= int'($past(th_hi)));

  // R11, R12: RTS drops when its control is off or the FIFOs are disabled
  assert_rts_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_en || !fifo_en) |=> !rts);
endmodule

bind fifo_lvl_ctrl fifo_lvl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flag_clr(flag_clr),
  .rx_count(rx_count), .tx_count(tx_count),
  .th_hi(cfg_q.rx_hi_th), .rts_en(cfg_q.rts_en),
  .rx_hi_flag(rx_hi_flag), .rx_ready(rx_ready), .tx_ready(tx_ready), .rts(rts)
);

// File: tb/sim_fifo_lvl_ctrl.sv
module sim_fifo_lvl_ctrl;
  localparam int D  = 8;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, fifo_en = 1'b1, cfg_wr = 1'b0, flag_clr = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic rx_hi_flag, rx_lo_flag, tx_lo_flag, rx_ready, tx_ready, rts;

  fifo_lvl_ctrl #(.DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_count(rx_count),
    .tx_count(tx_count), .flag_clr(flag_clr), .rx_hi_flag(rx_hi_flag),
    .rx_lo_flag(rx_lo_flag), .tx_lo_flag(tx_lo_flag), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .rts(rts)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  // bench-side model state
  logic [31:0] mcfg = '0;
  bit en = 1, fh = 0, fl = 0, ft = 0, mr = 0;
  int pr = 0, pt = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int need(int m, bit e);
    if (!e) return 1;
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic logic [31:0] word(int hi, int lo, int tt, bit fr, int rm, int tm);
    return {2'b00, 6'(lo), 2'b00, 6'(hi), 2'b00, 6'(tt), fr, 1'b0, 2'(rm), 2'b00, 2'(tm)};
  endfunction

  task automatic tick(int rxc, int txc, bit clr, bit wr, logic [31:0] wd);
    int t1, t2, tt, rm, tm;
    bit fr, ch, cl, ct;
    @(negedge clk);
    fifo_en = en; rx_count = CW'(rxc); tx_count = CW'(txc);
    flag_clr = clr; cfg_wr = wr; cfg_wdata = wd;
    t1 = int'(mcfg[21:16]); t2 = int'(mcfg[29:24]); tt = int'(mcfg[13:8]);
    fr = mcfg[7]; rm = int'(mcfg[5:4]); tm = int'(mcfg[1:0]);
    #1;
    chk(en ? "R8 rx_ready" : "R12 rx_ready", 32'(rx_ready), 32'(rxc >= need(rm, en)));
    chk(en ? "R9 tx_ready" : "R12 tx_ready", 32'(tx_ready), 32'((D - txc) >= need(tm, en)));
    @(posedge clk);
    ch = en && pr < t1 && rxc >= t1;
    cl = en && pr > t2 && rxc <= t2;
    ct = en && pt > tt && txc <= tt;
    fh = (fh && !clr) || ch;
    fl = (fl && !clr) || cl;
    ft = (ft && !clr) || ct;
    if (en && fr) begin
      if (rxc >= t1) mr = 1;
      else if (rxc <= t2) mr = 0;
    end else mr = 0;
    pr = rxc; pt = txc;
    if (wr) mcfg = wd & 32'h3F3F3FB3;
    #1;
    chk(clr ? "R7 rx_hi_flag" : (en ? "R4 rx_hi_flag" : "R12 rx_hi_flag"), 32'(rx_hi_flag), 32'(fh));
    chk(clr ? "R7 rx_lo_flag" : "R5 rx_lo_flag", 32'(rx_lo_flag), 32'(fl));
    chk(clr ? "R7 tx_lo_flag" : "R6 tx_lo_flag", 32'(tx_lo_flag), 32'(ft));
    chk((en && fr) ? "R10 rts" : "R11 rts", 32'(rts), 32'(mr));
    chk(en ? "R2 cfg_rdata" : "R3 cfg_rdata", cfg_rdata, en ? mcfg : 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 rx_hi_flag", 32'(rx_hi_flag), 0);
    chk("R1 rx_lo_flag", 32'(rx_lo_flag), 0);
    chk("R1 tx_lo_flag", 32'(tx_lo_flag), 0);
    chk("R1 rts", 32'(rts), 0);
    chk("R1 cfg_rdata", cfg_rdata, 0);
    // full write with unused bits set: R2 masking
    tick(0, 0, 0, 1, 32'hFFFF_FFFF);
    // exhaustive count-pair sweep for each level setting
    for (int th = 0; th <= D + 1; th++) begin
      tick(0, 0, 1, 1, word(th, (th * 7 + 3) % (D + 2), (th * 3 + 1) % (D + 2),
                           1'b1, th % 4, (th + 1) % 4));
      for (int p = 0; p <= D; p++)
        for (int c = 0; c <= D; c++) begin
          tick(p, D - p, p % 2 == 1, 0, 0);
          tick(c, D - c, 0, 0, 0);
        end
    end
    // R11: RTS control disabled
    tick(0, 0, 1, 1, word(4, 2, 3, 1'b0, 2, 2));
    for (int k = 0; k <= 2 * D; k++) tick(k <= D ? k : 2 * D - k, k % (D + 1), 0, 0, 0);
    // R3, R12: FIFOs disabled, then re-enabled
    tick(0, D, 1, 1, word(3, 2, 5, 1'b1, 2, 2));
    tick(D, D, 0, 0, 0);
    en = 0;
    for (int p = 0; p <= D; p++)
      for (int c = 0; c <= D; c += 2) begin
        tick(p, p, 0, 0, 0);
        tick(c, D - c, 0, 0, 0);
      end
    en = 1;
    tick(0, 0, 0, 0, 0);
    tick(D, D, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule